// File: doc/BRIEF.md
# Configuration Register Bank with Block-Write Staging

This block holds the configuration bytes of a clock-generator controller behind a serial management link whose bit layer has already been decoded into bytes. An upstream receiver reports the start of a transfer, each received byte and the stop of the transfer. It also forwards read requests from the host, and the bank answers each one with one byte and a one-cycle ready pulse. Twenty-five 8-bit registers, numbered 0 to 24, drive the core logic in parallel at all times.

Writes are block writes only. After each start the first two bytes are a command code and a byte count; both are consumed and thrown away. Each later byte fills the next register, counting up from register 0. Three register groups (14 to 15, 16 to 17, and 18 to 20) are held in a staging buffer and reach the outputs together, and only once the last member of the group has arrived in the same transfer. A stop or a fresh start before that drops the staged bytes. Register 6 sets how many bytes a read-back returns. A few registers are fixed or strap-derived and cannot be written.

Top module: `smbcfg_bank`

## Requirements
- R1: After a start, the first two bytes are discarded and the third byte writes register 0. Each later byte writes the next higher register. A write to an ungrouped, writable register appears on `cfg_o` (register i at bits 8i+7..8i) one cycle after the byte is accepted.
- R2: A stop ends the transfer. Bytes presented while no transfer is active change no register.
- R3: Registers 14 and 15, 16 and 17, and 18, 19 and 20 each update together on `cfg_o` one cycle after the group's last member is accepted, and only when every member arrived in that transfer.
- R4: A stop or a new start that arrives before a group's last byte leaves every member of that group unchanged. Registers already written earlier in the transfer keep their new values.
- R5: Register 6 resets to 06h. A write of 00h to it stores 01h, and any other value is stored as written.
- R6: After a start, each read request returns the next register, starting at register 0. The value appears on `rd_dat_o` with `rd_rdy_o` high for one cycle, in the cycle after the request. Once the number of requests served equals register 6, further requests get no ready pulse.
- R7: Data bytes aimed at register indices above 24 change nothing. Read-back at indices above 24 returns FFh.
- R8: Register 7 always reads the bitwise inverse of `strap_i` as sampled during reset. Writes to it and later changes of `strap_i` have no effect on it.
- R9: Register 10 always reads 00h. Register 11 reads {REV_HI, 0001b} and register 12 reads REV_LO. Writes to any of these three have no effect.
- R10: Reset values are as follows. Registers 1 to 5 and 9: FFh. Registers 0, 8, 13 and 24: 00h. Registers 14 to 20: 3Ch, 12h, 00h, 0Ah, 11h, 22h, 44h. Registers 21 to 23: 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples `strap_i` |
| strap_i | input | 8 | Board strap levels, latched while in reset |
| xfer_start_i | input | 1 | One-cycle pulse: start of a transfer |
| xfer_stop_i | input | 1 | One-cycle pulse: stop of a transfer |
| byte_vld_i | input | 1 | A received byte is present on `byte_dat_i` |
| byte_dat_i | input | 8 | Received byte |
| rd_req_i | input | 1 | One-cycle pulse: host wants the next read-back byte |
| rd_rdy_o | output | 1 | Read-back byte valid on `rd_dat_o` |
| rd_dat_o | output | 8 | Read-back byte |
| cfg_o | output | 200 | All 25 registers; register i at bits 8i+7..8i |

## Verification
The write index lives in a single counter. If that counter slips, every later byte of the transfer lands one register off, and the parallel outputs differ from the reference one cycle after the first misplaced byte. A group that commits early or keeps stale staged bytes shows up as a changed first member after a transfer that was cut short, one cycle after the byte that triggered it. A wrong read pointer or count shows up at the first read-back byte it affects: a wrong value, or a ready pulse present or missing on the request after the count.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

    localparam int DW      = 8;
    localparam int NREG    = 25;
    localparam int IW      = $clog2(NREG);
    localparam int PW      = 8;
    localparam int HDR_LEN = 2;
    localparam int NGRP    = 3;

    localparam int RG_CNT   = 6;
    localparam int RG_STRAP = 7;
    localparam int RG_RSVD  = 10;
    localparam int RG_ID0   = 11;
    localparam int RG_ID1   = 12;

    localparam logic [3:0] VENDOR_NIB = 4'b0001;

    typedef struct packed {
        logic          en;
        logic [PW-1:0] idx;
        logic [DW-1:0] dat;
    } wr_req_t;

    function automatic int grp_first(input int g);
        case (g)
            0:       return 14;
            1:       return 16;
            default: return 18;
        endcase
    endfunction

    function automatic int grp_last(input int g);
        case (g)
            0:       return 15;
            1:       return 17;
            default: return 20;
        endcase
    endfunction

    function automatic int grp_of(input int i);
        for (int g = 0; g < NGRP; g++) begin
            if (i >= grp_first(g) && i <= grp_last(g)) return g;
        end
        return -1;
    endfunction

    function automatic bit is_fixed(input int i);
        return (i == RG_STRAP) || (i == RG_RSVD) || (i == RG_ID0) || (i == RG_ID1);
    endfunction

    function automatic logic [DW-1:0] dflt(input int i);
        case (i)
            1, 2, 3, 4, 5, 9: return 8'hFF;
            RG_CNT:           return 8'h06;
            14:               return 8'h3C;
            15:               return 8'h12;
            17:               return 8'h0A;
            18:               return 8'h11;
            19:               return 8'h22;
            20:               return 8'h44;
            21, 22, 23:       return 8'h80;
            default:          return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smbcfg_wr_seq.sv
module smbcfg_wr_seq
    import smbcfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          vld_i,
    input  logic [DW-1:0] dat_i,
    output wr_req_t       wr_o,
    output logic          abort_o
);

    logic [PW-1:0] pos;
    logic          active;

    always_comb begin
        wr_o.en  = vld_i && active && !start_i && !stop_i && (pos >= PW'(HDR_LEN));
        wr_o.idx = pos - PW'(HDR_LEN);
        wr_o.dat = dat_i;
        abort_o  = start_i || stop_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            active <= 1'b0;
        end else if (start_i) begin
            pos    <= '0;
            active <= 1'b1;
        end else if (stop_i) begin
            active <= 1'b0;
        end else if (vld_i && active && (pos != {PW{1'b1}})) begin
            pos <= pos + PW'(1);
        end
    end

    a_r2_idle_silent: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(active) && !start_i) |-> !wr_o.en);

endmodule

// File: rtl/smbcfg_store.sv
module smbcfg_store
    import smbcfg_pkg::*;
#(
    parameter logic [3:0]    REV_HI = 4'h2,
    parameter logic [DW-1:0] REV_LO = 8'h03
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DW-1:0]            strap_i,
    input  wr_req_t                  wr_i,
    input  logic                     abort_i,
    output logic [NREG-1:0][DW-1:0]  rb_o
);

    logic [DW-1:0]   strap_q;
    logic [NGRP-1:0] commit;

    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_i;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int F = grp_first(g);
        localparam int L = grp_last(g);
        logic pend;

        assign commit[g] = wr_i.en && (wr_i.idx == PW'(L)) && pend;

        always_ff @(posedge clk) begin
            if (rst || abort_i)                         pend <= 1'b0;
            else if (wr_i.en && wr_i.idx == PW'(F))     pend <= 1'b1;
            else if (commit[g])                         pend <= 1'b0;
        end

        a_r3_grp_atomic: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && (rb_o[F] != $past(rb_o[F])))
            |-> ($past(wr_i.en) && ($past(wr_i.idx) == PW'(L))));
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam int G = grp_of(i);
        if (is_fixed(i)) begin : g_fix
            if (i == RG_STRAP) begin : g_strap
                assign rb_o[i] = ~strap_q;
            end else if (i == RG_ID0) begin : g_id0
                assign rb_o[i] = {REV_HI, VENDOR_NIB};
            end else if (i == RG_ID1) begin : g_id1
                assign rb_o[i] = REV_LO;
            end else begin : g_zero
                assign rb_o[i] = '0;
            end
        end else if (G >= 0) begin : g_gmem
            logic [DW-1:0] val;
            logic [DW-1:0] nxt;
            if (i == grp_last(G)) begin : g_tail
                assign nxt = wr_i.dat;
            end else begin : g_body
                logic [DW-1:0] shd;
                always_ff @(posedge clk) begin
                    if (rst)                                 shd <= '0;
                    else if (wr_i.en && wr_i.idx == PW'(i))  shd <= wr_i.dat;
                end
                assign nxt = shd;
            end
            always_ff @(posedge clk) begin
                if (rst)            val <= dflt(i);
                else if (commit[G]) val <= nxt;
            end
            assign rb_o[i] = val;
        end else begin : g_plain
            logic [DW-1:0] val;
            always_ff @(posedge clk) begin
                if (rst) begin
                    val <= dflt(i);
                end else if (wr_i.en && wr_i.idx == PW'(i)) begin
                    if (i == RG_CNT && wr_i.dat == '0) val <= DW'(1);
                    else                               val <= wr_i.dat;
                end
            end
            assign rb_o[i] = val;
        end
    end

    a_r5_cnt_nonzero: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rb_o[RG_CNT] != '0));

    a_r7_high_idx_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_i.en && wr_i.idx >= PW'(NREG)) |=> $stable(rb_o));

endmodule

// File: rtl/smbcfg_rd_port.sv
module smbcfg_rd_port
    import smbcfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     req_i,
    input  logic [NREG-1:0][DW-1:0]  rb_i,
    output logic                     rdy_o,
    output logic [DW-1:0]            dat_o
);

    logic [PW-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            rdy_o <= 1'b0;
            dat_o <= '0;
        end else begin
            rdy_o <= 1'b0;
            if (start_i) begin
                ptr <= '0;
            end else if (req_i && (ptr < rb_i[RG_CNT])) begin
                rdy_o <= 1'b1;
                dat_o <= (ptr < PW'(NREG)) ? rb_i[ptr[IW-1:0]] : {DW{1'b1}};
                ptr   <= ptr + PW'(1);
            end
        end
    end

    a_r6_rdy_follows_req: assert property (@(posedge clk) disable iff (rst)
        rdy_o |-> ($past(req_i) && !$past(rst)));

endmodule

// File: rtl/smbcfg_bank.sv
module smbcfg_bank
    import smbcfg_pkg::*;
#(
    parameter logic [3:0]    REV_HI = 4'h2,
    parameter logic [DW-1:0] REV_LO = 8'h03
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DW-1:0]      strap_i,
    input  logic               xfer_start_i,
    input  logic               xfer_stop_i,
    input  logic               byte_vld_i,
    input  logic [DW-1:0]      byte_dat_i,
    input  logic               rd_req_i,
    output logic               rd_rdy_o,
    output logic [DW-1:0]      rd_dat_o,
    output logic [NREG*DW-1:0] cfg_o
);

    wr_req_t                 wr;
    logic                    abort;
    logic [NREG-1:0][DW-1:0] rb;

    smbcfg_wr_seq u_wr_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (xfer_start_i),
        .stop_i  (xfer_stop_i),
        .vld_i   (byte_vld_i),
        .dat_i   (byte_dat_i),
        .wr_o    (wr),
        .abort_o (abort)
    );

    smbcfg_store #(
        .REV_HI (REV_HI),
        .REV_LO (REV_LO)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .strap_i (strap_i),
        .wr_i    (wr),
        .abort_i (abort),
        .rb_o    (rb)
    );

    smbcfg_rd_port u_rd_port (
        .clk     (clk),
        .rst     (rst),
        .start_i (xfer_start_i),
        .req_i   (rd_req_i),
        .rb_i    (rb),
        .rdy_o   (rd_rdy_o),
        .dat_o   (rd_dat_o)
    );

    assign cfg_o = rb;

endmodule

// File: tb/smbcfg_bank_bench.sv
module smbcfg_bank_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   strap = 8'h5A;
    logic         st = 1'b0, sp = 1'b0, vld = 1'b0, req = 1'b0;
    logic [7:0]   dat = 8'h00;
    logic         rdy;
    logic [7:0]   rdat;
    logic [199:0] cfg;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] mdl [25];
    logic [7:0] stg [25];
    bit         have [25];
    bit         active = 1'b0;
    int         pos = 0;
    logic [7:0] wbuf [32];

    always #2 clk = ~clk;

    smbcfg_bank u_smbcfg_bank (
        .clk(clk), .rst(rst), .strap_i(strap),
        .xfer_start_i(st), .xfer_stop_i(sp),
        .byte_vld_i(vld), .byte_dat_i(dat),
        .rd_req_i(req), .rd_rdy_o(rdy), .rd_dat_o(rdat),
        .cfg_o(cfg)
    );

    // R10 reset values, R9 fixed registers
    function automatic logic [7:0] rst_val(int i);
        case (i)
            1, 2, 3, 4, 5, 9: return 8'hFF;
            6:  return 8'h06;
            11: return 8'h21;
            12: return 8'h03;
            14: return 8'h3C;
            15: return 8'h12;
            17: return 8'h0A;
            18: return 8'h11;
            19: return 8'h22;
            20: return 8'h44;
            21, 22, 23: return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(int i);
        if (i == 6) return "R5";
        if (i == 7) return "R8";
        if (i >= 10 && i <= 12) return "R9";
        if (i >= 14 && i <= 20) return "R3";
        return "R1";
    endfunction

    task automatic clr_stage();
        for (int i = 0; i < 25; i++) have[i] = 1'b0;
    endtask

    task automatic apply(int k, logic [7:0] d);
        if (k > 24 || k == 7 || k == 10 || k == 11 || k == 12) return;
        case (k)
            14, 16, 18, 19: begin stg[k] = d; have[k] = 1'b1; end
            15: if (have[14]) begin mdl[14] = stg[14]; mdl[15] = d; end
            17: if (have[16]) begin mdl[16] = stg[16]; mdl[17] = d; end
            20: if (have[18] && have[19]) begin
                    mdl[18] = stg[18]; mdl[19] = stg[19]; mdl[20] = d;
                end
            6:  mdl[6] = (d == 8'h00) ? 8'h01 : d;
            default: mdl[k] = d;
        endcase
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 25; i++) mdl[i] = rst_val(i);
            mdl[7] = ~strap;
            active = 1'b0;
            pos = 0;
            clr_stage();
        end else if (st) begin
            active = 1'b1; pos = 0; clr_stage();
        end else if (sp) begin
            active = 1'b0; clr_stage();
        end else if (vld && active) begin
            if (pos >= 2) apply(pos - 2, dat);
            pos++;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] cb(int i);
        return cfg[8*i +: 8];
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 25; i++) chk(tag_of(i), cb(i), mdl[i]);
        end
    end

    task automatic pulse_start();
        @(negedge clk) st = 1'b1;
        @(negedge clk) st = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) sp = 1'b1;
        @(negedge clk) sp = 1'b0;
    endtask

    task automatic wr_xfer(int n, bit do_stop);
        pulse_start();
        for (int k = 0; k < n + 2; k++) begin
            vld = 1'b1;
            dat = (k < 2) ? 8'hA5 : wbuf[k-2];
            @(negedge clk);
        end
        vld = 1'b0;
        if (do_stop) pulse_stop();
    endtask

    task automatic rd_xfer(int n);
        int cnt;
        pulse_start();
        cnt = int'(mdl[6]);
        for (int k = 0; k < n; k++) begin
            req = 1'b1;
            @(negedge clk) req = 1'b0;
            chk("R6 rdy", {7'b0, rdy}, (k < cnt) ? 8'h01 : 8'h00);
            if (k < cnt) chk(k > 24 ? "R7 rd" : "R6 rd", rdat, (k > 24) ? 8'hFF : mdl[k]);
            @(negedge clk);
        end
        pulse_stop();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 50000 && !done) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        strap = 8'hFF;
        @(negedge clk);
        // R10 reset state
        chk("R10 reg6", cb(6), 8'h06);
        chk("R10 reg9", cb(9), 8'hFF);
        chk("R10 reg8", cb(8), 8'h00);
        chk("R10 reg21", cb(21), 8'h80);
        chk("R8 reg7", cb(7), 8'hA5);
        chk("R9 reg11", cb(11), 8'h21);
        chk("R9 reg12", cb(12), 8'h03);

        // full write, R1 R3 R8 R9
        for (int i = 0; i < 32; i++) wbuf[i] = 8'h40 + 8'(i);
        wr_xfer(25, 1'b1);
        chk("R1 reg0", cb(0), 8'h40);
        chk("R1 reg24", cb(24), 8'h58);
        chk("R3 reg15", cb(15), 8'h4F);
        chk("R3 reg20", cb(20), 8'h54);
        chk("R8 reg7", cb(7), 8'hA5);
        chk("R9 reg10", cb(10), 8'h00);
        chk("R9 reg11", cb(11), 8'h21);

        // R4: stop after register 14
        for (int i = 0; i < 32; i++) wbuf[i] = 8'h80 + 8'(i);
        wr_xfer(15, 1'b1);
        chk("R4 reg13", cb(13), 8'h8D);
        chk("R4 reg14", cb(14), 8'h4E);

        // R4: stop after register 19
        for (int i = 0; i < 32; i++) wbuf[i] = 8'hC0 + 8'(i);
        wr_xfer(20, 1'b1);
        chk("R3 reg17", cb(17), 8'hD1);
        chk("R4 reg18", cb(18), 8'h52);
        chk("R4 reg19", cb(19), 8'h53);

        // R4: new start instead of stop after register 16
        for (int i = 0; i < 32; i++) wbuf[i] = 8'h10 + 8'(i);
        wr_xfer(17, 1'b0);
        wr_xfer(0, 1'b1);
        chk("R4 reg15", cb(15), 8'h1F);
        chk("R4 reg16", cb(16), 8'hD0);

        // R2: bytes while idle
        for (int k = 0; k < 3; k++) begin
            vld = 1'b1; dat = 8'h77;
            @(negedge clk);
        end
        vld = 1'b0;
        @(negedge clk);
        chk("R2 reg0", cb(0), 8'h10);
        chk("R2 reg1", cb(1), 8'h11);

        // R5: count 00h clamps to 01h; R6 one byte read
        wbuf[6] = 8'h00;
        wr_xfer(7, 1'b1);
        chk("R5 reg6", cb(6), 8'h01);
        rd_xfer(2);

        // R6: count 3, four requests
        wbuf[6] = 8'h03;
        wr_xfer(7, 1'b1);
        rd_xfer(4);

        // R7: write past 24, read past 24
        for (int i = 0; i < 32; i++) wbuf[i] = 8'h20 + 8'(i);
        wbuf[6] = 8'd30;
        wr_xfer(28, 1'b1);
        chk("R7 reg24", cb(24), 8'h38);
        chk("R8 reg7", cb(7), 8'hA5);
        rd_xfer(27);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule